// File: doc/BRIEF.md
# Preemptive Parking Bus Arbiter

This block is the central arbiter for a shared parallel bus with nine request/grant pairs. Slot 0 belongs to the bridge's own master and slots 1 to 8 serve external masters. Every request and grant pin is active low. The block grants the bus to one master at a time. A new master is granted only while the bus is idle. When no one requests, the grant stays parked on the last owner. A configuration input can force parking back onto slot 0.

A master that keeps the bus busy while others wait can be preempted. Once a waiting master has been seen for a programmed number of clocks, the holder's grant is withdrawn. No grant is then given until the bus goes idle, and at that point the round-robin winner receives it. A strap input turns the arbiter off for use with an external arbiter. In that mode the slot-0 grant pin carries the bridge's own request and the slot-0 request pin is read as the incoming grant.

Top module: `park_arb`

## Requirements
- R1: After reset, and with the strap low, `gnt_n` equals 9'h1FE (slot 0 parked) and `ext_gnt` is 0.
- R2: With the strap low, at most one bit of `gnt_n` is low in any cycle.
- R3: The slot that holds or last held the grant changes only at a clock edge where `bus_idle` was high.
- R4: When a new owner is chosen, it is the first requesting slot found by stepping upward from the last owner in index order, wrapping from 8 to 0. The last owner is considered only when no other slot requests.
- R5: With no request and `park_self` low, the grant stays on the last owner.
- R6: With no request, `park_self` high and the bus idle, the grant moves to slot 0 at the next edge.
- R7: With `preempt_off` low, suppose another slot's request is sampled at L+1 consecutive edges while the owner holds the grant and `bus_idle` is low. After the (L+1)th such edge, all grants go high. L is the time-to-preempt.
- R8: With `preempt_off` high, a holder's grant is never withdrawn while the bus is busy.
- R9: After a withdrawal, all grants stay high until an edge with `bus_idle` high. At that edge the round-robin winner is granted, or the last owner is granted if nobody requests.
- R10: With `strap_ext` high, `gnt_n[8:1]` is all ones, `gnt_n[0]` equals `~own_req`, `ext_gnt` equals `~req_n[0]`, and `req_n[8:1]` has no effect on any output.
- R11: `tp_sel` selects L as follows: 0 gives 0 clocks, and a value k from 1 to 7 gives 2^(k-1) clocks (1, 2, 4, 8, 16, 32, 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_ext | input | 1 | High selects external-arbiter mode |
| preempt_off | input | 1 | High disables preemption (low = enabled) |
| tp_sel | input | 3 | Time-to-preempt select |
| park_self | input | 1 | High forces parking on slot 0 |
| bus_idle | input | 1 | High when no transaction is in progress |
| own_req | input | 1 | Bridge request in external-arbiter mode, active high |
| req_n | input | 9 | Requests, active low; bit 0 is the incoming grant in external mode |
| gnt_n | output | 9 | Grants, active low; bit 0 is the outgoing request in external mode |
| ext_gnt | output | 1 | Bridge granted by the external arbiter |

## Verification
Two requesters on an idle bus show whether the rotation advances past the last owner or sticks on the lowest index. A busy bus with a second requester, repeated for every `tp_sel` code, separates the eight preemption delays from each other. It also shows whether the grant reappears before the bus goes idle. Quiet periods with `park_self` low and then high separate parking on the last owner from parking on slot 0. Strap toggling with random slot-0 and outer request pins, followed by a long random mix, shows whether the pin repurposing works and whether more than one grant ever appears.

// File: rtl/arb_pkg.sv
// Shared helpers for the parking arbiter.
// Assumes the time-to-preempt select is a small code (a few bits wide).
package arb_pkg;
    // Decode a time-to-preempt code into a number of clocks.
    function automatic int unsigned tp_clocks(input int unsigned sel);
        return (sel == 0) ? 0 : (32'd1 << (sel - 1));
    endfunction
endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin selector: finds the first requesting slot after `last`, wrapping.
// `last` itself is the final candidate. Purely combinational.
module arb_rr_pick #(
    parameter int NSLOT = 9,
    localparam int IW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] req,
    input  logic [IW-1:0]    last,
    output logic             hit,
    output logic [IW-1:0]    pick
);
    // Scan from farthest to nearest so the nearest requester wins.
    always_comb begin
        hit  = 1'b0;
        pick = last;
        for (int k = NSLOT; k >= 1; k--) begin
            int t;
            t = int'(last) + k;
            if (t >= NSLOT) t = t - NSLOT;
            if (req[t]) begin
                hit  = 1'b1;
                pick = IW'(t);
            end
        end
    end

    // The chosen slot must be requesting.
    always_comb begin
        if (hit) assert (req[pick]); // R4
    end
endmodule

// File: rtl/arb_wait_timer.sv
// Counts clocks while a master waits behind a busy holder, saturating.
// Raises `expired` once the count reaches the decoded time-to-preempt.
module arb_wait_timer #(
    parameter int SELW = 3,
    localparam int CW = (1 << SELW) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SELW-1:0] sel,
    output logic            expired
);
    import arb_pkg::*;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Decode the select into a clock count.
    always_comb limit = CW'(tp_clocks(int'(sel)));

    // Count while enabled, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end

    // Expired when the wait has lasted the programmed time.
    always_comb expired = en && (cnt >= limit);

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0)); // R7
endmodule

// File: rtl/park_arb.sv
// Central bus arbiter with round-robin choice, timed preemption and parking.
// Assumes bus_idle is synchronous to clk. Grants move only on an idle bus;
// a withdrawn grant is reissued at the next idle cycle.
module park_arb #(
    parameter int NSLOT = 9,
    parameter int SELW  = 3,
    localparam int IW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_ext,
    input  logic             preempt_off,
    input  logic [SELW-1:0]  tp_sel,
    input  logic             park_self,
    input  logic             bus_idle,
    input  logic             own_req,
    input  logic [NSLOT-1:0] req_n,
    output logic [NSLOT-1:0] gnt_n,
    output logic             ext_gnt
);
    logic [IW-1:0]    owner;
    logic             gnt_on;
    logic [NSLOT-1:0] req;
    logic [NSLOT-1:0] own_mask;
    logic             others;
    logic             any_req;
    logic             hit;
    logic [IW-1:0]    pick;
    logic             wait_en;
    logic             expired;

    // Decode active-low requests; ignored in external mode.
    always_comb begin
        req      = strap_ext ? '0 : ~req_n;
        own_mask = NSLOT'(1) << owner;
        others   = |(req & ~own_mask);
        any_req  = |req;
        wait_en  = gnt_on && others && !bus_idle && !strap_ext;
    end

    arb_rr_pick #(.NSLOT(NSLOT)) u_pick (
        .req  (req),
        .last (owner),
        .hit  (hit),
        .pick (pick)
    );

    arb_wait_timer #(.SELW(SELW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wait_en),
        .sel     (tp_sel),
        .expired (expired)
    );

    // Ownership and grant state; held at slot 0 while the strap is high.
    always_ff @(posedge clk) begin
        if (!rst_n || strap_ext) begin
            owner  <= '0;
            gnt_on <= 1'b1;
        end else if (gnt_on) begin
            if (bus_idle && hit && pick != owner) owner <= pick;
            else if (bus_idle && !any_req && park_self) owner <= '0;
            else if (!bus_idle && !preempt_off && expired) gnt_on <= 1'b0;
        end else if (bus_idle) begin
            gnt_on <= 1'b1;
            if (hit) owner <= pick;
            else if (park_self) owner <= '0;
        end
    end

    // Drive pins for the selected mode.
    always_comb begin
        if (strap_ext) begin
            gnt_n    = '1;
            gnt_n[0] = ~own_req;
            ext_gnt  = ~req_n[0];
        end else begin
            gnt_n   = gnt_on ? ~own_mask : '1;
            ext_gnt = 1'b0;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_ext |-> ($countones(~gnt_n) <= 1)); // R2
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && !strap_ext) |=> (owner == $past(owner))); // R3
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt_off && gnt_on && !bus_idle && !strap_ext) |=> gnt_on); // R8
    AST_PARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_on && !any_req && !park_self && !strap_ext) |=> (gnt_on && $stable(owner))); // R5
    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ext |-> (&gnt_n[NSLOT-1:1])); // R10
endmodule

// File: tb/park_arb_test.sv
module park_arb_test;
    localparam int N = 9;

    logic clk = 0;
    logic rst_n = 0;
    logic strap_ext = 0, preempt_off = 0, park_self = 0, bus_idle = 1, own_req = 0;
    logic [2:0] tp_sel = 0;
    logic [N-1:0] req_n = '1;
    logic [N-1:0] gnt_n;
    logic ext_gnt;

    int total = 0, bad = 0, cycles = 0;
    bit chk_on = 0;
    string tag = "R1";

    // behavioural model state
    int m_own = 0, m_cnt = 0, m_lim, m_pick;
    bit m_on = 1, m_oth, m_any, m_en, m_exp;

    park_arb uut (.clk(clk), .rst_n(rst_n), .strap_ext(strap_ext), .preempt_off(preempt_off),
        .tp_sel(tp_sel), .park_self(park_self), .bus_idle(bus_idle), .own_req(own_req),
        .req_n(req_n), .gnt_n(gnt_n), .ext_gnt(ext_gnt));

    always #10 clk = ~clk;

    task automatic check(input string t, input bit ok, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act, exp, cycles);
        end
    endtask

    // Reference model: updated on each rising edge from the stable inputs.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || strap_ext) begin
            m_own = 0; m_on = 1; m_cnt = 0;
        end else begin
            m_lim = (tp_sel == 0) ? 0 : (1 << (tp_sel - 1));
            m_any = 0; m_oth = 0; m_pick = -1;
            for (int d = 1; d <= N; d++) begin
                int s;
                s = (m_own + d) % N;
                if (!req_n[s]) begin
                    m_any = 1;
                    if (s != m_own) m_oth = 1;
                    if (m_pick < 0) m_pick = s;
                end
            end
            m_en  = m_on && m_oth && !bus_idle;
            m_exp = m_en && (m_cnt >= m_lim);
            if (m_on) begin
                if (bus_idle && m_pick >= 0 && m_pick != m_own) m_own = m_pick;
                else if (bus_idle && !m_any && park_self) m_own = 0;
                else if (!bus_idle && !preempt_off && m_exp) m_on = 0;
            end else if (bus_idle) begin
                m_on = 1;
                if (m_pick >= 0) m_own = m_pick;
                else if (park_self) m_own = 0;
            end
            m_cnt = m_en ? ((m_cnt < 127) ? m_cnt + 1 : 127) : 0;
        end
    end

    // Compare pins against the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            logic [N-1:0] eg;
            logic ee;
            if (strap_ext) begin
                eg = '1; eg[0] = ~own_req; ee = ~req_n[0];
            end else begin
                eg = m_on ? ~(N'(1) << m_own) : '1; ee = 1'b0;
            end
            check(tag, gnt_n === eg, gnt_n, eg);
            check({tag, " ext_gnt"}, ext_gnt === ee, N'(ext_gnt), N'(ee));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cycles > 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset park", gnt_n === 9'h1FE, gnt_n, 9'h1FE);
        chk_on = 1;
        step(4);

        tag = "R5"; req_n = ~9'h010; step(3); req_n = '1; step(5);
        @(negedge clk); check("R5 park last", gnt_n === ~9'h010, gnt_n, ~9'h010);

        tag = "R4"; req_n = ~9'h088; step(6);
        req_n = ~9'h101; step(4); req_n = '1; step(2);

        tag = "R3"; bus_idle = 0; preempt_off = 1; req_n = ~9'h022; step(10);
        bus_idle = 1; step(3); req_n = '1; step(2);

        tag = "R6"; park_self = 1; step(3);
        @(negedge clk); check("R6 park self", gnt_n === 9'h1FE, gnt_n, 9'h1FE);
        park_self = 0;

        tag = "R8"; req_n = ~9'h004; step(2); bus_idle = 0; req_n = ~9'h024; step(80);
        bus_idle = 1; step(2); req_n = '1; step(2);

        preempt_off = 0;
        for (int s = 0; s < 8; s++) begin
            int n, lim;
            lim = (s == 0) ? 0 : (1 << (s - 1));
            tag = "R11"; tp_sel = 3'(s);
            bus_idle = 1; req_n = ~9'h004; step(3);
            tag = "R7"; bus_idle = 0; req_n = ~9'h024;
            n = 0;
            for (int w = 0; w < 100; w++) begin
                @(negedge clk);
                if (gnt_n !== '1) n++; else break;
            end
            check("R11 preempt delay", n == lim + 1, N'(n), N'(lim + 1));
            tag = "R9"; step(3);
            bus_idle = 1; step(1);
            @(negedge clk); check("R9 regrant", gnt_n === ~9'h020, gnt_n, ~9'h020);
            req_n = '1; step(2);
        end

        tag = "R10"; strap_ext = 1;
        for (int i = 0; i < 40; i++) begin
            req_n = N'($urandom); own_req = 1'($urandom); step(1);
        end
        strap_ext = 0; req_n = '1; step(2);
        @(negedge clk); check("R10 strap release", gnt_n === 9'h1FE, gnt_n, 9'h1FE);

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            req_n = N'($urandom) | N'($urandom);
            bus_idle = ($urandom % 3) != 0;
            if (i % 97 == 0) tp_sel = 3'($urandom);
            park_self = ($urandom % 8) == 0;
            preempt_off = ($urandom % 6) == 0;
            strap_ext = ($urandom % 50) == 0;
            own_req = 1'($urandom);
            step(1);
        end

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule